// File: doc/BRIEF.md
# Interrupt and NMI Entry Controller

This block decides, once per clock, whether a processor core takes a non-maskable interrupt or a level-3 maskable interrupt, and carries out the entry in a single edge. On entry it stores the current status word and the resume address into a pair of shadow registers that belong to the mode being entered. It rewrites the status word and loads the handler address. It then raises a one-cycle redirect strobe so that the fetch stage can jump.

A non-maskable request ignores the global mask. It is refused only while the mode field already reads NMI, so NMI handlers never nest. A level-3 request is held off by the global mask or by its own level mask. Its handler address is the vector base plus an offset that an external interrupt controller supplies. When both requests are allowed in the same cycle, NMI is taken. Neither entry waits for the pipeline: in-flight instructions finish, and the resume address is the first instruction that did not complete.

Top module: `irq_entry_ctrl`

## Requirements

The default status-word bit positions are: R at bit 15, GM at bit 16, I0M to I3M at bits 17 to 20, EM at bit 21, the mode field at bits 24:22, and J at bit 28. A request is "taken" when the redirect strobe rises on the next clock edge.

- R1: While `rst` is high, every output register reads zero after a clock edge. This covers the redirect strobe, status, PC and all four shadow registers.
- R2: An NMI request is taken whenever the mode field is not 3'b111, whatever the GM bit holds.
- R3: An NMI request is ignored while the mode field is 3'b111. No redirect occurs and the NMI shadow registers keep their values.
- R4: On NMI entry, `nmi_rsr_o` receives `sr_i` and `nmi_rar_o` receives `resume_pc_i`.
- R5: On NMI entry, `sr_o` equals `sr_i` with R and J cleared, the mode field set to 3'b111, and EM and GM set. `pc_o` equals `vec_base_i + 0x10`.
- R6: A level-3 request is ignored while GM (bit 16) or I3M (bit 20) is set. The other level masks and the mode field do not block it.
- R7: On level-3 entry, `int3_rsr_o` and `int3_rar_o` receive `sr_i` and `resume_pc_i`. `sr_o` equals `sr_i` with R and J cleared, the mode field set to 3'b101, and I0M to I3M all set.
- R8: On level-3 entry, `pc_o` equals `vec_base_i + vec_offset_i`.
- R9: When both requests are allowed in the same cycle, NMI entry is performed and the level-3 shadow registers are left unchanged.
- R10: In a cycle with no accepted request, `redirect_o` is low on the next edge, `sr_o` takes `sr_i`, and `pc_o` and all shadow registers hold.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req_i | input | 1 | Non-maskable interrupt request line |
| int3_req_i | input | 1 | Level-3 interrupt request line |
| vec_base_i | input | AW | Exception vector base register |
| vec_offset_i | input | AW | Handler offset from the external interrupt controller |
| resume_pc_i | input | AW | Address of the first non-completed instruction |
| sr_i | input | SW | Current status register |
| sr_o | output | SW | New status register |
| pc_o | output | AW | New program counter |
| redirect_o | output | 1 | One-cycle strobe marking an entry |
| nmi_rsr_o | output | SW | NMI return-status shadow register |
| nmi_rar_o | output | AW | NMI return-address shadow register |
| int3_rsr_o | output | SW | Level-3 return-status shadow register |
| int3_rar_o | output | AW | Level-3 return-address shadow register |

## Verification

The properties assume that the core writes `sr_o` back into `sr_i` before it presents another request. Without that write-back, a request held across the redirect edge would be judged against the stale status word. The stimulus meets this assumption by applying each request for exactly one cycle. It then drops all requests for an idle cycle. The status word it drives during a request already carries whatever mode and mask state the case needs.

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter int R_BIT = 15,
  parameter int GM_BIT = 16,
  parameter int I0M_BIT = 17,
  parameter int I1M_BIT = 18,
  parameter int I2M_BIT = 19,
  parameter int I3M_BIT = 20,
  parameter int EM_BIT = 21,
  parameter int MODE_LSB = 22,
  parameter int J_BIT = 28,
  parameter logic [AW-1:0] NMI_OFFSET = 'h10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nmi_req_i,
  input  logic          int3_req_i,
  input  logic [AW-1:0] vec_base_i,
  input  logic [AW-1:0] vec_offset_i,
  input  logic [AW-1:0] resume_pc_i,
  input  logic [SW-1:0] sr_i,
  output logic [SW-1:0] sr_o,
  output logic [AW-1:0] pc_o,
  output logic          redirect_o,
  output logic [SW-1:0] nmi_rsr_o,
  output logic [AW-1:0] nmi_rar_o,
  output logic [SW-1:0] int3_rsr_o,
  output logic [AW-1:0] int3_rar_o
);
  localparam logic [2:0] MODE_NMI  = 3'b111;
  localparam logic [2:0] MODE_INT3 = 3'b101;
  localparam logic [SW-1:0] CLR_MASK =
    (SW'(1) << R_BIT) | (SW'(1) << J_BIT) | (SW'(7) << MODE_LSB);
  localparam logic [SW-1:0] NMI_SET =
    (SW'(MODE_NMI) << MODE_LSB) | (SW'(1) << EM_BIT) | (SW'(1) << GM_BIT);
  localparam logic [SW-1:0] INT3_SET =
    (SW'(MODE_INT3) << MODE_LSB) | (SW'(1) << I0M_BIT) | (SW'(1) << I1M_BIT) |
    (SW'(1) << I2M_BIT) | (SW'(1) << I3M_BIT);

  logic nmi_take, int3_take;
  logic [SW-1:0] kept_sr;

  assign nmi_take  = nmi_req_i && (sr_i[MODE_LSB +: 3] != MODE_NMI);
  assign int3_take = int3_req_i && !sr_i[GM_BIT] && !sr_i[I3M_BIT] && !nmi_take;
  assign kept_sr   = sr_i & ~CLR_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_o       <= '0;
      pc_o       <= '0;
      redirect_o <= 1'b0;
      nmi_rsr_o  <= '0;
      nmi_rar_o  <= '0;
      int3_rsr_o <= '0;
      int3_rar_o <= '0;
    end else begin
      redirect_o <= nmi_take || int3_take;
      if (nmi_take) begin
        nmi_rsr_o <= sr_i;
        nmi_rar_o <= resume_pc_i;
        sr_o      <= kept_sr | NMI_SET;
        pc_o      <= vec_base_i + NMI_OFFSET;
      end else if (int3_take) begin
        int3_rsr_o <= sr_i;
        int3_rar_o <= resume_pc_i;
        sr_o       <= kept_sr | INT3_SET;
        pc_o       <= vec_base_i + vec_offset_i;
      end else begin
        sr_o <= sr_i;
      end
    end
  end
endmodule

module irq_entry_ctrl_chk #(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter int GM_BIT = 16,
  parameter int I3M_BIT = 20,
  parameter int MODE_LSB = 22,
  parameter logic [AW-1:0] NMI_OFFSET = 'h10
) (
  input logic          clk,
  input logic          rst,
  input logic          nmi_req_i,
  input logic          int3_req_i,
  input logic [AW-1:0] vec_base_i,
  input logic [AW-1:0] vec_offset_i,
  input logic [AW-1:0] resume_pc_i,
  input logic [SW-1:0] sr_i,
  input logic [SW-1:0] sr_o,
  input logic [AW-1:0] pc_o,
  input logic          redirect_o,
  input logic [SW-1:0] nmi_rsr_o,
  input logic [AW-1:0] nmi_rar_o,
  input logic [SW-1:0] int3_rar_o
);
  logic nmi_ok, int3_ok;
  assign nmi_ok  = nmi_req_i && (sr_i[MODE_LSB +: 3] != 3'b111);
  assign int3_ok = int3_req_i && !sr_i[GM_BIT] && !sr_i[I3M_BIT];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !redirect_o && pc_o == '0 && nmi_rar_o == '0);
  // R2
  nmi_take_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_ok |=> redirect_o && sr_o[MODE_LSB +: 3] == 3'b111);
  // R3
  nmi_block_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_i[MODE_LSB +: 3] == 3'b111 && !int3_req_i) |=> !redirect_o && $stable(nmi_rar_o));
  // R4
  nmi_save_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_ok |=> nmi_rsr_o == $past(sr_i) && nmi_rar_o == $past(resume_pc_i));
  // R5
  nmi_pc_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_ok |=> pc_o == $past(vec_base_i) + NMI_OFFSET);
  // R6
  int3_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!nmi_req_i && int3_req_i && !int3_ok) |=> !redirect_o);
  // R7
  int3_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!nmi_ok && int3_ok) |=> redirect_o && sr_o[MODE_LSB +: 3] == 3'b101 && int3_rar_o == $past(resume_pc_i));
  // R8
  int3_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!nmi_ok && int3_ok) |=> pc_o == $past(vec_base_i) + $past(vec_offset_i));
  // R9
  nmi_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (nmi_ok && int3_ok) |=> sr_o[MODE_LSB +: 3] == 3'b111 && $stable(int3_rar_o));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!nmi_req_i && !int3_req_i) |=> !redirect_o && sr_o == $past(sr_i) && $stable(pc_o));
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
  .AW(AW), .SW(SW), .GM_BIT(GM_BIT), .I3M_BIT(I3M_BIT),
  .MODE_LSB(MODE_LSB), .NMI_OFFSET(NMI_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .nmi_req_i(nmi_req_i), .int3_req_i(int3_req_i),
  .vec_base_i(vec_base_i), .vec_offset_i(vec_offset_i), .resume_pc_i(resume_pc_i),
  .sr_i(sr_i), .sr_o(sr_o), .pc_o(pc_o), .redirect_o(redirect_o),
  .nmi_rsr_o(nmi_rsr_o), .nmi_rar_o(nmi_rar_o), .int3_rar_o(int3_rar_o)
);

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic nmi_req_i = 1'b0, int3_req_i = 1'b0;
  logic [31:0] vec_base_i = '0, vec_offset_i = '0, resume_pc_i = '0, sr_i = '0;
  logic [31:0] sr_o, pc_o, nmi_rsr_o, nmi_rar_o, int3_rsr_o, int3_rar_o;
  logic redirect_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  irq_entry_ctrl uut (.*);

  always #10 clk = ~clk;

  localparam logic [31:0] RJ   = 32'h1000_8000;
  localparam logic [31:0] MODE = 32'h01C0_0000;
  localparam logic [31:0] NMI_BITS  = 32'h01C0_0000 | 32'h0020_0000 | 32'h0001_0000;
  localparam logic [31:0] INT3_BITS = 32'h0140_0000 | 32'h001E_0000;

  // {nmi, int3, sr, offset, kind}  kind: 0 none, 1 nmi, 2 int3
  localparam logic [67:0] VEC [11] = '{
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 2'd1},
    {1'b1, 1'b0, 32'h1001_8000, 32'h0000_0000, 2'd1},
    {1'b1, 1'b0, 32'h01C0_0000, 32'h0000_0000, 2'd0},
    {1'b0, 1'b1, 32'h0000_0000, 32'h0000_0024, 2'd2},
    {1'b0, 1'b1, 32'h0001_0000, 32'h0000_0030, 2'd0},
    {1'b0, 1'b1, 32'h0010_0000, 32'h0000_0034, 2'd0},
    {1'b1, 1'b1, 32'h0000_8000, 32'h0000_0040, 2'd1},
    {1'b0, 1'b1, 32'h01C0_0000, 32'h0000_0044, 2'd2},
    {1'b1, 1'b1, 32'h01C0_0000, 32'h0000_0048, 2'd2},
    {1'b0, 1'b0, 32'h1000_0000, 32'h0000_004C, 2'd0},
    {1'b0, 1'b1, 32'h0008_8000, 32'h0000_0050, 2'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_pc, e_nrsr, e_nrar, e_irsr, e_irar, e_sr;
    sr_i = 32'hFFFF_FFFF; nmi_req_i = 1'b1; vec_base_i = 32'h1234_0000;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 redirect", {31'b0, redirect_o}, 32'h0);
    check("R1 sr", sr_o, 32'h0);
    check("R1 pc", pc_o, 32'h0);
    check("R1 nmi_rsr", nmi_rsr_o, 32'h0);
    check("R1 int3_rar", int3_rar_o, 32'h0);
    nmi_req_i = 1'b0; sr_i = '0;
    rst = 1'b0;
    @(negedge clk);
    e_pc = 0; e_nrsr = 0; e_nrar = 0; e_irsr = 0; e_irar = 0;
    for (int i = 0; i < 11; i++) begin
      logic [67:0] v;
      v = VEC[i];
      nmi_req_i = v[67]; int3_req_i = v[66]; sr_i = v[65:34]; vec_offset_i = v[33:2];
      vec_base_i = 32'h8000_0000 + 32'(i) * 32'h100;
      resume_pc_i = 32'h0000_1000 + 32'(i) * 4;
      e_sr = sr_i;
      if (v[1:0] == 2'd1) begin
        e_sr = (sr_i & ~(RJ | MODE)) | NMI_BITS;
        e_pc = vec_base_i + 32'h10;
        e_nrsr = sr_i; e_nrar = resume_pc_i;
      end else if (v[1:0] == 2'd2) begin
        e_sr = (sr_i & ~(RJ | MODE)) | INT3_BITS;
        e_pc = vec_base_i + vec_offset_i;
        e_irsr = sr_i; e_irar = resume_pc_i;
      end
      @(negedge clk);
      // R2 R3 R6 R9 taken or not; R5 R7 status; R5 R8 pc; R4 R7 shadows
      check($sformatf("R2/R3/R6/R9 redirect vec%0d", i), {31'b0, redirect_o}, {31'b0, v[1:0] != 2'd0});
      check($sformatf("R5/R7/R10 sr vec%0d", i), sr_o, e_sr);
      check($sformatf("R5/R8 pc vec%0d", i), pc_o, e_pc);
      check($sformatf("R4 nmi_rsr vec%0d", i), nmi_rsr_o, e_nrsr);
      check($sformatf("R4 nmi_rar vec%0d", i), nmi_rar_o, e_nrar);
      check($sformatf("R7 R9 int3_rsr vec%0d", i), int3_rsr_o, e_irsr);
      check($sformatf("R7 R9 int3_rar vec%0d", i), int3_rar_o, e_irar);
      nmi_req_i = 1'b0; int3_req_i = 1'b0; sr_i = 32'h0000_0ABC;
      @(negedge clk);
      // R10 idle: strobe lasts one cycle, sr follows input, pc holds
      check($sformatf("R10 strobe low vec%0d", i), {31'b0, redirect_o}, 32'h0);
      check($sformatf("R10 sr follow vec%0d", i), sr_o, 32'h0000_0ABC);
      check($sformatf("R10 pc hold vec%0d", i), pc_o, e_pc);
    end
    // R3 NMI blocked while in NMI mode even with GM clear and all else idle
    nmi_req_i = 1'b1; sr_i = MODE;
    @(negedge clk);
    check("R3 nested nmi ignored", {31'b0, redirect_o}, 32'h0);
    check("R3 nmi_rar held", nmi_rar_o, e_nrar);
    nmi_req_i = 1'b0;
    // R1 reset mid-run clears shadows
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset nmi_rar", nmi_rar_o, 32'h0);
    check("R1 mid reset int3_rsr", int3_rsr_o, 32'h0);
    check("R1 mid reset pc", pc_o, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule